// File: doc/BRIEF.md
# Composite sync separator with burst gate

The block takes separate horizontal and vertical sync lines, merges them into one composite sync, and resamples it on a clock that runs at twice the colour subcarrier frequency. A source that already produces composite sync holds the vertical input high and feeds the horizontal input, which then passes straight through. Both sync inputs are active low.

Every low pulse of the resampled sync is timed in sample clocks. When the pulse ends, the block reports it as a line sync, a narrow equalizing pulse or a long vertical (broad/serration) pulse. The NTSC/PAL select picks one of two sets of width windows, and a pulse outside every window is dropped. A burst gate follows only a pulse that was reported as a line sync. The gate opens a fixed number of sample clocks after the falling edge of the resampled sync and stays open for roughly nine subcarrier cycles. A one-cycle clamp strobe follows every falling edge, whatever kind of pulse it starts.

Top module: `sync_burst_gen`

## Requirements
- R1: `csync_o` equals the XNOR of `hsync_i` and `vsync_i` two clock edges later. When `vsync_i` is held high, `csync_o` follows `hsync_i`, and a low input pulse of W cycles gives a `csync_o` low pulse of W cycles.
- R2: While `rst_ni` is low, `csync_o` is 1 and `burst_o`, `clamp_o` and `kind_valid_o` are 0. Asserting reset during a burst drops `burst_o` at once.
- R3: For every `csync_o` falling edge, `clamp_o` is high for exactly one cycle, which is the cycle after the first low cycle of `csync_o`.
- R4: W is the number of cycles `csync_o` stays low. One cycle after `csync_o` rises, `kind_valid_o` pulses for one cycle with `kind_o` set as follows: 1 means line sync, 2 means equalizing, 3 means broad.
- R5: With `pal_i`=0 the windows are: W<=21 is equalizing, 29<=W<=43 is line sync, and W>=71 is broad. With `pal_i`=1 they are: W<=26 is equalizing, 35<=W<=53 is line sync, and W>=88 is broad.
- R6: A pulse whose width falls in no window gives no `kind_valid_o` and no burst.
- R7: After a line-sync pulse, `burst_o` rises exactly 46 cycles (NTSC) or 56 cycles (PAL) after the first low cycle of `csync_o`. It then stays high for 18 (NTSC) or 20 (PAL) consecutive cycles, and `csync_o` stays high throughout.
- R8: After an equalizing pulse or a broad pulse, `burst_o` stays low.
- R9: The width counter saturates at 127 and does not wrap. A pulse still low after 127 cycles is reported once as broad (`kind_o`=3), 128 cycles after its first low cycle, and nothing is reported when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock at twice the subcarrier frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, or composite sync when `vsync_i` is high |
| vsync_i | input | 1 | Vertical sync, tied high for composite-sync sources |
| pal_i | input | 1 | 0 selects NTSC windows and timing, 1 selects PAL |
| csync_o | output | 1 | Resampled composite sync |
| clamp_o | output | 1 | One-cycle strobe after each sync falling edge |
| kind_valid_o | output | 1 | Pulse classification strobe |
| kind_o | output | 2 | Pulse kind: 1 line sync, 2 equalizing, 3 broad |
| burst_o | output | 1 | Burst gate |

## Verification
The assertions assume that every sync period is longer than the end of the burst window, which is 76 sample clocks. Under that assumption a new falling edge never arrives while a gate is open, so the gate can never overlap a sync tip. They also assume that `pal_i` does not change while a pulse is being measured. The stimulus changes `pal_i` only when the line is idle, and it follows every pulse with at least 130 high cycles, so both assumptions always hold.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_HORIZ = 2'd1,
    PK_EQUAL = 2'd2,
    PK_BROAD = 2'd3
  } pulse_kind_e;
endpackage

// File: rtl/sbg_sampler.sv
module sbg_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  output logic sync_o,
  output logic fall_o,
  output logic rise_o,
  output logic clamp_o
);
  // [0] first sample, [1] resampled sync, [2] previous resampled value
  logic [2:0] sh_q;
  logic       clamp_q;

  assign sync_o  = sh_q[1];
  assign fall_o  = sh_q[2] & ~sh_q[1];
  assign rise_o  = ~sh_q[2] & sh_q[1];
  assign clamp_o = clamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '1;
      clamp_q <= 1'b0;
    end else begin
      sh_q    <= {sh_q[1:0], hsync_i ~^ vsync_i};
      clamp_q <= fall_o;
    end
  end

  AST_CLAMP_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sh_q[1]) |=> clamp_q); // R3
endmodule

// File: rtl/sbg_width_meter.sv
module sbg_width_meter #(
  parameter int CNT_W     = 7,
  parameter int NT_EQ_MAX = 21,
  parameter int NT_H_MIN  = 29,
  parameter int NT_H_MAX  = 43,
  parameter int NT_BR_MIN = 71,
  parameter int PL_EQ_MAX = 26,
  parameter int PL_H_MIN  = 35,
  parameter int PL_H_MAX  = 53,
  parameter int PL_BR_MIN = 88
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       fall_i,
  input  logic       rise_i,
  input  logic       pal_i,
  output logic       kind_valid_o,
  output logic [1:0] kind_o
);
  import sbg_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             sat_q;
  logic [CNT_W-1:0] eq_max, h_min, h_max, br_min;
  pulse_kind_e      cls;
  logic             kv_q;
  pulse_kind_e      kind_q;

  always_comb begin
    eq_max = pal_i ? CNT_W'(PL_EQ_MAX) : CNT_W'(NT_EQ_MAX);
    h_min  = pal_i ? CNT_W'(PL_H_MIN)  : CNT_W'(NT_H_MIN);
    h_max  = pal_i ? CNT_W'(PL_H_MAX)  : CNT_W'(NT_H_MAX);
    br_min = pal_i ? CNT_W'(PL_BR_MIN) : CNT_W'(NT_BR_MIN);
    if (cnt_q <= eq_max)                        cls = PK_EQUAL;
    else if (cnt_q >= h_min && cnt_q <= h_max)  cls = PK_HORIZ;
    else if (cnt_q >= br_min)                   cls = PK_BROAD;
    else                                        cls = PK_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sat_q  <= 1'b0;
      kv_q   <= 1'b0;
      kind_q <= PK_NONE;
    end else begin
      kv_q <= 1'b0;
      if (fall_i) begin
        cnt_q <= CNT_W'(1);
        sat_q <= 1'b0;
      end else if (!sync_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (rise_i && !sat_q && cls != PK_NONE) begin
        kv_q   <= 1'b1;
        kind_q <= cls;
      end
      // still low past the counter range: report broad once
      if (!sync_i && !fall_i && cnt_q == CNT_MAX && !sat_q) begin
        kv_q   <= 1'b1;
        kind_q <= PK_BROAD;
        sat_q  <= 1'b1;
      end
    end
  end

  assign kind_valid_o = kv_q;
  assign kind_o       = kind_q;

  AST_SINGLE_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kv_q |=> !kv_q); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !fall_i) |=> cnt_q == CNT_MAX); // R9
  AST_KIND_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kv_q |-> kind_q != PK_NONE); // R6
endmodule

// File: rtl/sbg_burst_timer.sv
module sbg_burst_timer #(
  parameter int CNT_W        = 7,
  parameter int NT_BST_START = 46,
  parameter int NT_BST_LEN   = 18,
  parameter int PL_BST_START = 56,
  parameter int PL_BST_LEN   = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fall_i,
  input  logic       pal_i,
  input  logic       kind_valid_i,
  input  logic [1:0] kind_i,
  output logic       burst_o
);
  import sbg_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tcnt_q;
  logic             armed_q;
  logic [CNT_W-1:0] b_start, b_end;

  always_comb begin
    b_start = pal_i ? CNT_W'(PL_BST_START) : CNT_W'(NT_BST_START);
    b_end   = pal_i ? CNT_W'(PL_BST_START + PL_BST_LEN)
                    : CNT_W'(NT_BST_START + NT_BST_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (fall_i)                  tcnt_q <= CNT_W'(1);
      else if (tcnt_q != CNT_MAX)  tcnt_q <= tcnt_q + 1'b1;
      if (fall_i)                                   armed_q <= 1'b0;
      else if (kind_valid_i && kind_i == PK_HORIZ)  armed_q <= 1'b1;
    end
  end

  assign burst_o = armed_q && tcnt_q >= b_start && tcnt_q < b_end;

  AST_NO_ARM_ON_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_valid_i && kind_i != PK_HORIZ) |=> !armed_q); // R8
endmodule

// File: rtl/sync_burst_gen.sv
module sync_burst_gen #(
  parameter int CNT_W        = 7,
  parameter int NT_EQ_MAX    = 21,
  parameter int NT_H_MIN     = 29,
  parameter int NT_H_MAX     = 43,
  parameter int NT_BR_MIN    = 71,
  parameter int NT_BST_START = 46,
  parameter int NT_BST_LEN   = 18,
  parameter int PL_EQ_MAX    = 26,
  parameter int PL_H_MIN     = 35,
  parameter int PL_H_MAX     = 53,
  parameter int PL_BR_MIN    = 88,
  parameter int PL_BST_START = 56,
  parameter int PL_BST_LEN   = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       pal_i,
  output logic       csync_o,
  output logic       clamp_o,
  output logic       kind_valid_o,
  output logic [1:0] kind_o,
  output logic       burst_o
);
  logic sync_s, fall_s, rise_s;

  sbg_sampler u_sampler (
    .clk_i, .rst_ni, .hsync_i, .vsync_i,
    .sync_o(sync_s), .fall_o(fall_s), .rise_o(rise_s), .clamp_o(clamp_o)
  );

  sbg_width_meter #(
    .CNT_W(CNT_W),
    .NT_EQ_MAX(NT_EQ_MAX), .NT_H_MIN(NT_H_MIN), .NT_H_MAX(NT_H_MAX), .NT_BR_MIN(NT_BR_MIN),
    .PL_EQ_MAX(PL_EQ_MAX), .PL_H_MIN(PL_H_MIN), .PL_H_MAX(PL_H_MAX), .PL_BR_MIN(PL_BR_MIN)
  ) u_meter (
    .clk_i, .rst_ni, .sync_i(sync_s), .fall_i(fall_s), .rise_i(rise_s), .pal_i,
    .kind_valid_o, .kind_o
  );

  sbg_burst_timer #(
    .CNT_W(CNT_W),
    .NT_BST_START(NT_BST_START), .NT_BST_LEN(NT_BST_LEN),
    .PL_BST_START(PL_BST_START), .PL_BST_LEN(PL_BST_LEN)
  ) u_burst (
    .clk_i, .rst_ni, .fall_i(fall_s), .pal_i,
    .kind_valid_i(kind_valid_o), .kind_i(kind_o), .burst_o
  );

  assign csync_o = sync_s;

  AST_BURST_OUTSIDE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o |-> csync_o); // R7
endmodule

// File: tb/tb_sync_burst_gen.sv
module tb_sync_burst_gen;
  logic clk_i = 1'b0, rst_ni = 1'b0, hsync_i = 1'b1, vsync_i = 1'b1, pal_i = 1'b0;
  logic csync_o, clamp_o, kind_valid_o, burst_o;
  logic [1:0] kind_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  sync_burst_gen dut (.*);

  always #5 clk_i = ~clk_i;

  // {pal, low width, expected kind: 0 none, 1 line, 2 equalizing, 3 broad}
  localparam int NV = 19;
  localparam int VEC [NV][3] = '{
    '{0, 4, 2}, '{0, 21, 2}, '{0, 22, 0}, '{0, 29, 1}, '{0, 36, 1},
    '{0, 43, 1}, '{0, 44, 0}, '{0, 70, 0}, '{0, 71, 3}, '{0, 200, 3},
    '{1, 26, 2}, '{1, 27, 0}, '{1, 35, 1}, '{1, 45, 1}, '{1, 53, 1},
    '{1, 54, 0}, '{1, 87, 0}, '{1, 88, 3}, '{1, 200, 3}
  };

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_pulse(int pal, int w, int ek);
    int fall_idx = -1, rel = 0, low_n = 0, clamp_n = 0, clamp_rel = -1;
    int kv_n = 0, kv_kind = 0, kv_rel = -1, b_n = 0, b_rel = -1;
    int exp_start = pal ? 56 : 46;
    int exp_len = pal ? 20 : 18;
    pal_i = pal[0];
    vsync_i = 1'b1;
    for (int k = 0; k < w + 140; k++) begin
      @(negedge clk_i);
      if (fall_idx < 0 && !csync_o) fall_idx = k;
      if (fall_idx >= 0) begin
        rel = k - fall_idx;
        if (!csync_o) low_n++;
        if (clamp_o) begin clamp_n++; clamp_rel = rel; end
        if (kind_valid_o) begin kv_n++; kv_kind = int'(kind_o); kv_rel = rel; end
        if (burst_o) begin if (b_n == 0) b_rel = rel; b_n++; end
      end
      hsync_i = (k < w) ? 1'b0 : 1'b1;
    end
    chk("R1", $sformatf("low width w=%0d", w), low_n, w);
    chk("R3", $sformatf("clamp count w=%0d", w), clamp_n, 1);
    chk("R3", $sformatf("clamp position w=%0d", w), clamp_rel, 1);
    chk(ek == 0 ? "R6" : "R4", $sformatf("report count pal=%0d w=%0d", pal, w), kv_n, ek == 0 ? 0 : 1);
    if (ek != 0) begin
      chk("R5", $sformatf("kind pal=%0d w=%0d", pal, w), kv_kind, ek);
      chk(w > 127 ? "R9" : "R4", $sformatf("report time w=%0d", w), kv_rel, w > 127 ? 128 : w + 1);
    end
    chk(ek == 1 ? "R7" : "R8", $sformatf("burst length pal=%0d w=%0d", pal, w), b_n, ek == 1 ? exp_len : 0);
    if (ek == 1) chk("R7", $sformatf("burst start pal=%0d w=%0d", pal, w), b_rel, exp_start);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R2", "csync in reset", int'(csync_o), 1);
    chk("R2", "burst in reset", int'(burst_o), 0);
    chk("R2", "clamp in reset", int'(clamp_o), 0);
    chk("R2", "kind_valid in reset", int'(kind_valid_o), 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);

    // R1: XNOR merge with two-edge latency
    hsync_i = 1'b0; vsync_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", "xnor 0,0", int'(csync_o), 1);
    hsync_i = 1'b1;
    @(negedge clk_i);
    chk("R1", "xnor latency", int'(csync_o), 1);
    @(negedge clk_i);
    chk("R1", "xnor 1,0", int'(csync_o), 0);
    vsync_i = 1'b1;
    repeat (200) @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_pulse(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R2: reset while the gate is open
    pal_i = 1'b0;
    hsync_i = 1'b0;
    repeat (36) @(negedge clk_i);
    hsync_i = 1'b1;
    for (int k = 0; k < 100 && !burst_o; k++) @(negedge clk_i);
    chk("R2", "burst before reset", int'(burst_o), 1);
    rst_ni = 1'b0;
    #1;
    chk("R2", "burst on reset", int'(burst_o), 0);
    chk("R2", "csync on reset", int'(csync_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (150) @(negedge clk_i);
    chk("R2", "burst after reset", int'(burst_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule